// File: doc/BRIEF.md
# Coherency Unit Control Register Block

This block is the software-visible register file of a small multicore coherency unit. It sits on a simple 32-bit register bus. Each access carries a byte address, a write enable, four byte strobes, write data and a read enable. The block holds four things:

- a one-bit enable control;
- a read-only configuration word built from the core-count parameter;
- a 32-bit per-core power status word that can be written one byte at a time;
- a few address slots that read as zero.

The coherency, snoop and cache-maintenance machinery is not part of this block. It consumes the stored control and power values elsewhere.

Only the word offset of an address is decoded, so narrow accesses of 1, 2 or 4 bytes reach the word-wide registers. Read data is registered and appears one cycle after the read enable. An access to an address the block does not decode raises a one-cycle sideband pulse in that same following cycle, so a bus monitor can log it.

Top module: `ccu_regblk`

## Requirements
- R1: Word offset 0x00 holds the enable bit. A write with strobe bit 0 set stores write-data bit 0. A read returns that bit at bit 0, with bits 31:1 always zero. Reset clears the bit.
- R2: Word offset 0x04 reads bits 7:4 as a mask with one bit set for each present core (bits 0 to NUM_CORES-1 of that field), bits 1:0 as NUM_CORES-1, and every other bit as zero. Writes to it change nothing. NUM_CORES must be 1 to 4; any other value stops elaboration.
- R3: Word offset 0x08 is the 32-bit power status word. Any byte address from 0x08 to 0x0B selects it. Strobe bit i replaces only byte i (bits 8i+7:8i) with the matching write-data byte. Reset clears the whole word.
- R4: Word offset 0x0C always reads zero. Writes to it alter no other register.
- R5: Word offsets 0x40 and 0x44 read zero, ignore writes, and never raise the unsupported pulse.
- R6: Every other word offset, including 0x50 and 0x54, reads zero and ignores writes. Each read or write there drives bus_unsup high for the single cycle after the access. A decoded offset never drives it high.
- R7: bus_rdata is registered. It carries the addressed value in the cycle after bus_rd is high, and is zero in the cycle after a cycle with bus_rd low. A read and a write in the same cycle return the value held before that write. Reset drives bus_rdata and bus_unsup to zero.
- R8: Address bits 1:0 do not affect decoding. A byte address selects the same register as its word-aligned address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address within the 0x100-byte window |
| bus_wr | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes, bit i covers data bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| bus_unsup | output | 1 | One-cycle pulse after an access to an undecoded offset |

## Verification
The bench sends byte writes to 0x09, 0x0A and 0x0B.
- A design that decoded the full byte address would drop these writes.
- A design that ignored the strobes would overwrite bytes the bench expects to survive.

It writes all ones to the control and configuration offsets and then reads them back. This catches a control bit that keeps upper bits, and a configuration word that accepts writes.

It reads and writes 0x40, 0x44, 0x50 and 0x54, and a scatter of other offsets. A wrong decode shows up either as a missing or extra unsupported pulse, or as non-zero read data. Same-cycle read-and-write accesses expose a read path that forwards the new value instead of returning the old one.

// File: rtl/ccu_regs_pkg.sv
package ccu_regs_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int WOFF_W  = 6;
    localparam int MAX_CORES = 4;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_CFG,
        SEL_PWR,
        SEL_INV,
        SEL_FILT,
        SEL_UNSUP
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        reg_sel_e          sel;
    } acc_t;

    function automatic reg_sel_e decode_word(input logic [WOFF_W-1:0] w);
        case (w)
            6'h00:   return SEL_CTRL;
            6'h01:   return SEL_CFG;
            6'h02:   return SEL_PWR;
            6'h03:   return SEL_INV;
            6'h10,
            6'h11:   return SEL_FILT;
            default: return SEL_UNSUP;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input int n);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[7:4] = 4'((1 << n) - 1);
        w[1:0] = 2'(n - 1);
        return w;
    endfunction

endpackage

// File: rtl/ccu_decode.sv
module ccu_decode
    import ccu_regs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output acc_t              acc
);
    localparam int WORD_LSB = 2;

    logic unused_lo;
    assign unused_lo = ^addr[WORD_LSB-1:0];

    always_comb begin
        acc.rd    = rd;
        acc.wr    = wr;
        acc.be    = be;
        acc.wdata = wdata;
        acc.sel   = decode_word(WOFF_W'(addr[ADDR_W-1:WORD_LSB]));
    end
endmodule

// File: rtl/ccu_pwr_status.sv
module ccu_pwr_status
    import ccu_regs_pkg::*;
#(
    parameter int NLANES = LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [NLANES-1:0] be,
    input  logic [NLANES*8-1:0] wd,
    output logic [NLANES*8-1:0] q
);
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                q[i*8 +: 8] <= '0;
            else if (we && be[i])
                q[i*8 +: 8] <= wd[i*8 +: 8];
        end
    end
endmodule

// File: rtl/ccu_readback.sv
module ccu_readback
    import ccu_regs_pkg::*;
#(
    parameter int NUM_CORES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic              ctrl_q,
    input  logic [DATA_W-1:0] pwr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              unsup
);
    localparam logic [DATA_W-1:0] CFG = cfg_word(NUM_CORES);

    logic [DATA_W-1:0] mux_d;

    always_comb begin
        unique case (acc.sel)
            SEL_CTRL: mux_d = {{(DATA_W-1){1'b0}}, ctrl_q};
            SEL_CFG:  mux_d = CFG;
            SEL_PWR:  mux_d = pwr_q;
            default:  mux_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            unsup <= 1'b0;
        end else begin
            rdata <= acc.rd ? mux_d : '0;
            unsup <= (acc.rd || acc.wr) && (acc.sel == SEL_UNSUP);
        end
    end
endmodule

// File: rtl/ccu_regblk.sv
module ccu_regblk
    import ccu_regs_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_unsup
);
    // R2: legal core count only
    if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_bad_cores
        $error("ccu_regblk: NUM_CORES must lie in 1..4");
    end

    acc_t              acc;
    logic              ctrl_q;
    logic [DATA_W-1:0] pwr_q;

    ccu_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .acc   (acc)
    );

    // R1: single stored enable bit
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= 1'b0;
        else if (acc.wr && acc.sel == SEL_CTRL && acc.be[0])
            ctrl_q <= acc.wdata[0];
    end

    ccu_pwr_status #(.NLANES(LANES)) u_pwr (
        .clk (clk),
        .rst (rst),
        .we  (acc.wr && acc.sel == SEL_PWR),
        .be  (acc.be),
        .wd  (acc.wdata),
        .q   (pwr_q)
    );

    ccu_readback #(.NUM_CORES(NUM_CORES)) u_rb (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .ctrl_q (ctrl_q),
        .pwr_q  (pwr_q),
        .rdata  (bus_rdata),
        .unsup  (bus_unsup)
    );
endmodule

// File: rtl/ccu_regblk_chk.sv
module ccu_regblk_chk
    import ccu_regs_pkg::*;
#(
    parameter int NUM_CORES = 1,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_unsup
);
    logic [5:0] w;
    logic       decoded;
    assign w = bus_addr[7:2];
    assign decoded = (w == 6'h00) || (w == 6'h01) || (w == 6'h02) ||
                     (w == 6'h03) || (w == 6'h10) || (w == 6'h11);

    p_ctrl_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_rd) && $past(w) == 6'h00) |-> bus_rdata[31:1] == '0);

    p_cfg_value_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_rd) && $past(w) == 6'h01) |-> bus_rdata == cfg_word(NUM_CORES));

    // R4 and R5: invalidate and filter slots read zero
    p_zero_slots_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_rd) &&
         ($past(w) == 6'h03 || $past(w) == 6'h10 || $past(w) == 6'h11)) |-> bus_rdata == '0);

    p_unsup_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> bus_unsup == (($past(bus_rd) || $past(bus_wr)) && !$past(decoded)));

    p_unsup_rdata_r6: assert property (@(posedge clk) disable iff (rst)
        bus_unsup |-> bus_rdata == '0);

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_rd)) |-> bus_rdata == '0);
endmodule

bind ccu_regblk ccu_regblk_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_unsup (bus_unsup)
);

// File: tb/ccu_regblk_test.sv
module ccu_regblk_test;
    localparam int NC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_unsup;

    int vecs = 0;
    int errs = 0;
    logic        m_ctrl = 1'b0;
    logic [31:0] m_pwr = '0;

    always #4 clk = ~clk;

    ccu_regblk #(.NUM_CORES(NC), .ADDR_W(8)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_unsup(bus_unsup)
    );

    function automatic logic known(input logic [7:0] a);
        logic [5:0] w = a[7:2];
        return w == 6'h00 || w == 6'h01 || w == 6'h02 || w == 6'h03 ||
               w == 6'h10 || w == 6'h11;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a[7:2])
            6'h00:   return {31'b0, m_ctrl};
            6'h01:   return 32'h0000_0070 | 32'(NC - 1);
            6'h02:   return m_pwr;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic rd, input logic [7:0] a);
        if (!rd)                 return "R7";
        if (a[1:0] != 2'b00)     return "R8";
        case (a[7:2])
            6'h00:   return "R1";
            6'h01:   return "R2";
            6'h02:   return "R3";
            6'h03:   return "R4";
            6'h10,
            6'h11:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // entered and left at a falling edge
    task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
        logic [31:0] er;
        logic        eu;
        er = rd ? exp_read(a) : 32'h0;
        eu = (rd || wr) && !known(a);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
        if (wr) begin
            if (a[7:2] == 6'h00 && be[0]) m_ctrl = wd[0];
            if (a[7:2] == 6'h02)
                for (int i = 0; i < 4; i++)
                    if (be[i]) m_pwr[i*8 +: 8] = wd[i*8 +: 8];
        end
        @(posedge clk);
        @(negedge clk);
        check(tag_of(rd, a), bus_rdata, er);
        check("R6", {31'b0, bus_unsup}, {31'b0, eu});
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7: reset state of outputs
        check("R7", bus_rdata, 32'h0);
        check("R7", {31'b0, bus_unsup}, 32'h0);
        step(1, 0, 8'h00, 4'h0, 0);               // R1 reset value
        step(1, 0, 8'h08, 4'h0, 0);               // R3 reset value
        step(0, 1, 8'h00, 4'hF, 32'hFFFF_FFFF);   // R1 keeps bit 0 only
        step(1, 0, 8'h00, 4'h0, 0);
        step(0, 1, 8'h04, 4'hF, 32'hFFFF_FFFF);   // R2 write ignored
        step(1, 0, 8'h04, 4'h0, 0);
        step(0, 1, 8'h09, 4'h2, 32'h0000_AB00);   // R3 / R8 byte lane 1
        step(0, 1, 8'h0B, 4'h8, 32'h5A00_0000);
        step(1, 0, 8'h0A, 4'h0, 0);
        step(1, 1, 8'h08, 4'hF, 32'h1234_5678);   // R7 old value on read+write
        step(1, 0, 8'h08, 4'h0, 0);
        step(0, 1, 8'h0C, 4'hF, 32'hFFFF_FFFF);   // R4
        step(1, 0, 8'h0C, 4'h0, 0);
        step(0, 1, 8'h40, 4'hF, 32'hFFFF_FFFF);   // R5
        step(1, 0, 8'h44, 4'h0, 0);
        step(1, 0, 8'h50, 4'h0, 0);               // R6
        step(0, 1, 8'h54, 4'hF, 32'hFFFF_FFFF);
        step(0, 0, 8'h50, 4'h0, 0);               // R6 no pulse when idle
        step(1, 0, 8'h00, 4'h0, 0);
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            logic [2:0] k;
            k = 3'($urandom);
            case (k)
                3'd0: a = 8'h00;
                3'd1: a = 8'h04;
                3'd2, 3'd3: a = 8'h08;
                3'd4: a = 8'h0C;
                3'd5: a = ($urandom & 1) ? 8'h44 : 8'h40;
                3'd6: a = ($urandom & 1) ? 8'h54 : 8'h50;
                default: a = 8'($urandom);
            endcase
            a[1:0] = 2'($urandom);
            step(1'($urandom), 1'($urandom), a, 4'($urandom), $urandom);
        end
        step(0, 0, 8'h00, 4'h0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule